// File: doc/BRIEF.md
# Pixel Hit Counter with Chained Shift Readout

Each pixel of an imaging matrix keeps a binary count of the hits its discriminator reports during an exposure. This block holds that count in twelve storage bits and reuses the same bits as one link of a serial readout chain. The chain runs through all pixels of a column: each pixel takes its serial input from the previous pixel and drives its serial output into the next one.

In count mode, every rising edge of the qualified hit input adds one to the stored value. The value wraps to zero after its largest code. In shift mode, the hit path is cut off. The readout clock then arrives as two phases that must never be high together. The first phase captures the stored bits and the incoming serial bit into a holding stage. The second phase writes the held bits back one position toward the most significant bit, and the captured serial bit enters at bit 0.

The serial output is always the most significant stored bit. After one capture/advance pair per bit, the value of a pixel has moved entirely into its neighbour. A synchronous clear empties both the count and the holding stage before an acquisition. The whole block is modelled on one system clock, and the phase inputs are treated as levels sampled on that clock.

Top module: `pixel_count_shift`

## Requirements
- R1: While reset is asserted, the stored value and the holding stage are zero and `ser_out` is 0.
- R2: With `shift_mode` = 0, every rising edge of `hit` (high in this cycle, low in the previous one) raises the stored value by exactly one on that clock edge. A `hit` held high for many cycles counts once.
- R3: When a hit arrives at value 4095, the stored value becomes 0 on that edge.
- R4: `clear` = 1 zeroes the stored value and the holding stage on the next edge. It overrides hits and both read phases.
- R5: With `shift_mode` = 1, hits have no effect on the stored value.
- R6: With `shift_mode` = 0, `phi1` and `phi2` have no effect on the stored value.
- R7: `ser_out` always equals bit 11 of the stored value.
- R8: With `shift_mode` = 1, the two phases act as follows:
  - `phi1` = 1 with `phi2` = 0 copies the stored value and `ser_in` into the holding stage and leaves the stored value unchanged.
  - `phi2` = 1 with `phi1` = 0 loads the stored value with {held bits 10..0, held serial bit}.
  - Repeating either phase without the other has no further effect.
- R9: With `shift_mode` = 1, a cycle in which `phi1` and `phi2` are both 1 changes neither the stored value nor the holding stage.
- R10: Twelve full read cycles (`phi1` pulse, then `phi2` pulse) deliver the old value on `ser_out` MSB first. They leave the stored value equal to the twelve `ser_in` bits, taken most significant first, each sampled during its `phi1` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear | input | 1 | Zero count and holding stage |
| shift_mode | input | 1 | 0 = count hits, 1 = serial readout |
| hit | input | 1 | Qualified hit from the discriminator logic |
| phi1 | input | 1 | Read phase one (capture) |
| phi2 | input | 1 | Read phase two (advance) |
| ser_in | input | 1 | Serial data from the previous pixel |
| ser_out | output | 1 | Serial data to the next pixel (stored MSB) |

## Verification
A corrupted stored bit stays hidden until readout. The only exception is bit 11, which shows on `ser_out` one edge after it changes. Any other wrong bit appears on `ser_out` after as many read cycles as it sits below the MSB, so a full twelve-cycle read exposes every bit. A fault in the holding stage or the phase decode shows up as a misplaced or duplicated bit in the next read word. A counting fault shows up as an off-by-one or a missed wrap in the value read after a known number of hit edges.

// File: rtl/pix_cnt_pkg.sv
package pix_cnt_pkg;

    localparam int unsigned DEF_CNT_W = 12;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_CAPTURE  = 2'd1,
        PH_ADVANCE  = 2'd2,
        PH_CONFLICT = 2'd3
    } phase_act_e;

endpackage

// File: rtl/pix_hit_qual.sv
module pix_hit_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic enable,
    output logic hit_pulse
);

    typedef struct packed {
        logic prev;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = hit;
        hit_pulse = enable & hit & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pix_phase_dec.sv
module pix_phase_dec
    import pix_cnt_pkg::*;
(
    input  logic       shift_mode,
    input  logic       phi1,
    input  logic       phi2,
    output phase_act_e action
);

    always_comb begin
        action = PH_IDLE;
        if (shift_mode) begin
            unique case ({phi1, phi2})
                2'b11:   action = PH_CONFLICT;
                2'b10:   action = PH_CAPTURE;
                2'b01:   action = PH_ADVANCE;
                default: action = PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pix_stage_bank.sv
module pix_stage_bank
    import pix_cnt_pkg::*;
#(
    parameter int unsigned W = DEF_CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    input  phase_act_e   action,
    input  logic         ser_in,
    output logic [W-1:0] cnt,
    output logic [W-1:0] slv,
    output logic         sin_held
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] slv;
        logic         sin;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            unique case (action)
                PH_CAPTURE: begin
                    st_d.slv = st_q.cnt;
                    st_d.sin = ser_in;
                end
                PH_ADVANCE: begin
                    st_d.cnt = {st_q.slv[W-2:0], st_q.sin};
                end
                PH_CONFLICT: begin
                    st_d = st_q;
                end
                default: begin
                    if (inc) st_d.cnt = st_q.cnt + 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt      = st_q.cnt;
    assign slv      = st_q.slv;
    assign sin_held = st_q.sin;

endmodule

// File: rtl/pixel_count_shift.sv
module pixel_count_shift
    import pix_cnt_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic shift_mode,
    input  logic hit,
    input  logic phi1,
    input  logic phi2,
    input  logic ser_in,
    output logic ser_out
);

    localparam int unsigned MSB = CNT_W - 1;

    logic             hit_pulse;
    phase_act_e       action;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] slave_q;
    logic             sin_q;

    // Hits reach the counter only in count mode (count switch).
    pix_hit_qual u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .enable    (~shift_mode),
        .hit_pulse (hit_pulse)
    );

    pix_phase_dec u_dec (
        .shift_mode (shift_mode),
        .phi1       (phi1),
        .phi2       (phi2),
        .action     (action)
    );

    pix_stage_bank #(.W(CNT_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .inc      (hit_pulse),
        .action   (action),
        .ser_in   (ser_in),
        .cnt      (cnt_q),
        .slv      (slave_q),
        .sin_held (sin_q)
    );

    assign ser_out = cnt_q[MSB];

endmodule

// File: rtl/pix_cnt_checker.sv
module pix_cnt_checker #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clear,
    input logic         shift_mode,
    input logic         phi1,
    input logic         phi2,
    input logic         ser_out,
    input logic [W-1:0] cnt,
    input logic [W-1:0] slv,
    input logic         sin_cap
);

    a_r1_reset_zero: assert property (@(posedge clk)
        !rst_n |=> (cnt == '0 && slv == '0 && ser_out == 1'b0));

    a_r2_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_mode && !clear) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_mode && !clear && cnt == {W{1'b1}}) |=> (cnt == '0 || cnt == {W{1'b1}}));

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cnt == '0 && slv == '0 && ser_out == 1'b0));

    a_r5_shift_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode && !clear && !phi2) |=> $stable(cnt));

    a_r6_count_holds_slave: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_mode && !clear) |=> $stable(slv));

    a_r8_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode && phi2 && !phi1 && !clear) |=> (cnt == {$past(slv[W-2:0]), $past(sin_cap)}));

    a_r9_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_mode && phi1 && phi2 && !clear) |=> ($stable(cnt) && $stable(slv)));

endmodule

bind pixel_count_shift pix_cnt_checker #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (clear),
    .shift_mode (shift_mode),
    .phi1       (phi1),
    .phi2       (phi2),
    .ser_out    (ser_out),
    .cnt        (cnt_q),
    .slv        (slave_q),
    .sin_cap    (sin_q)
);

// File: tb/tb_pixel_count_shift.sv
module tb_pixel_count_shift;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 12;
    localparam int N_VEC      = 8;
    localparam int HITS [N_VEC] = '{0, 1, 2, 5, 37, 4095, 4096, 4097};
    localparam int EXPV [N_VEC] = '{0, 1, 2, 5, 37, 4095, 0, 1};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clear = 1'b0;
    logic shift_mode = 1'b0;
    logic hit = 1'b0;
    logic phi1 = 1'b0;
    logic phi2 = 1'b0;
    logic ser_in = 1'b0;
    logic ser_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pixel_count_shift #(.CNT_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .shift_mode(shift_mode),
        .hit(hit), .phi1(phi1), .phi2(phi2), .ser_in(ser_in), .ser_out(ser_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic give_hits(input int n);
        for (int i = 0; i < n; i++) begin
            hit = 1'b1; tick();
            hit = 1'b0; tick();
        end
    endtask

    task automatic do_clear();
        clear = 1'b1; tick();
        clear = 1'b0;
    endtask

    // Twelve read cycles; returns the word seen on ser_out, MSB first.
    task automatic read_word(output logic [W-1:0] v, input logic [W-1:0] sin_pat);
        shift_mode = 1'b1; tick();
        for (int i = 0; i < W; i++) begin
            v[W-1-i] = ser_out;
            ser_in = sin_pat[W-1-i];
            phi1 = 1'b1; tick();
            phi1 = 1'b0; phi2 = 1'b1; tick();
            phi2 = 1'b0;
        end
        ser_in = 1'b0;
        shift_mode = 1'b0; tick();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : main
        logic [W-1:0] v;
        repeat (3) tick();
        check("R1 ser_out in reset", ser_out, 0);
        rst_n = 1'b1; tick();
        read_word(v, '0);
        check("R1 value after reset", v, 0);

        // vector table: hits given, then value read (R2, R3)
        for (int k = 0; k < N_VEC; k++) begin
            do_clear();
            give_hits(HITS[k]);
            read_word(v, '0);
            check((k >= 6) ? "R3 wrap" : "R2 count", v, EXPV[k]);
        end

        // R2: long pulse counts once
        do_clear();
        hit = 1'b1; repeat (5) tick(); hit = 1'b0; tick();
        read_word(v, '0);
        check("R2 held hit once", v, 1);

        // R5: hits in shift mode ignored
        do_clear();
        give_hits(3);
        shift_mode = 1'b1; tick();
        give_hits(4);
        shift_mode = 1'b0; tick();
        read_word(v, '0);
        check("R5 shift ignores hits", v, 3);

        // R6: phases ignored in count mode
        do_clear();
        give_hits(2);
        for (int i = 0; i < 3; i++) begin
            phi1 = 1'b1; tick(); phi1 = 1'b0;
            phi2 = 1'b1; tick(); phi2 = 1'b0;
        end
        read_word(v, '0);
        check("R6 phases ignored", v, 2);

        // R10: load via chain, then read back
        do_clear();
        read_word(v, 12'hA5C);
        check("R10 old value out", v, 0);
        check("R7 msb of A5C", ser_out, 1);
        read_word(v, 12'hA5C);
        check("R10 chained value", v, 12'hA5C);

        // R9: overlapping phases do nothing
        shift_mode = 1'b1; tick();
        phi1 = 1'b1; phi2 = 1'b1; tick();
        phi1 = 1'b0; phi2 = 1'b0; tick();
        check("R9 overlap ser_out", ser_out, 1);
        shift_mode = 1'b0; tick();
        read_word(v, 12'hA5C);
        check("R9 overlap value", v, 12'hA5C);

        // R8: repeated phi1, repeated phi2
        shift_mode = 1'b1; tick();
        ser_in = 1'b1;
        phi1 = 1'b1; repeat (3) tick(); phi1 = 1'b0;
        ser_in = 1'b0;
        check("R8 capture keeps msb", ser_out, 1);
        phi2 = 1'b1; repeat (3) tick(); phi2 = 1'b0; tick();
        check("R7 msb after advance", ser_out, 0);
        shift_mode = 1'b0; tick();
        read_word(v, '0);
        check("R8 advance one place", v, 12'h4B9);

        // R4: clear beats a hit edge
        do_clear();
        give_hits(3);
        hit = 1'b1; clear = 1'b1; tick();
        clear = 1'b0; hit = 1'b0; tick();
        read_word(v, '0);
        check("R4 clear over hit", v, 0);

        // R4: clear beats phi2 in shift mode
        read_word(v, 12'hFFF);
        shift_mode = 1'b1; tick();
        phi1 = 1'b1; tick(); phi1 = 1'b0;
        phi2 = 1'b1; clear = 1'b1; tick();
        phi2 = 1'b0; clear = 1'b0; tick();
        check("R4 clear ser_out", ser_out, 0);
        shift_mode = 1'b0; tick();
        read_word(v, '0);
        check("R4 clear over advance", v, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule